// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit takes a 16-bit or 32-bit destination operand and a bit index. It copies the addressed bit into a carry output. Depending on a 2-bit operation code, it then leaves the operand as it is or returns it with that one bit complemented, cleared or set. The index comes either from an 8-bit immediate or from a register value as wide as the operand. Only as many low index bits as the operand width needs are used.

A caller presents the operands and pulses `start`. One cycle later `done` pulses for one cycle and the result, carry and write-enable are valid. These registered outputs hold their values until the next start. The write-enable tells the register file whether to store the returned operand.

Top module: `bit_test_modify`

## Requirements
- R1: After reset, `done`, `carry`, `wr_en` and `result` are all 0.
- R2: `done` is 1 in the cycle after a cycle with `start` high, and 0 in every other cycle.
- R3: On completion, `carry` equals bit k of the destination as it was before any change. k is the effective index.
- R4: When `is_wide`=0 (16-bit operand), k is the index taken modulo 16, which is its low 4 bits. Destination bits 31:16 are ignored, and `result[31:16]` is 0. When `is_wide`=1, k is the index modulo 32, which is its low 5 bits.
- R5: When `idx_from_reg`=0, the index is `imm_idx` (8 bits). When it is 1, the index is `reg_idx`, with only its operand-width low bits used.
- R6: With `op`=2'b00 (test), `result` equals the destination, masked to the operand width, and `wr_en` is 0.
- R7: With `op`=2'b01 (complement), `result` equals the destination with bit k inverted.
- R8: With `op`=2'b10 (reset), bit k of `result` is 0. With `op`=2'b11 (set), bit k of `result` is 1. All other bits of `result` equal the destination.
- R9: `wr_en` is 1 on completion of operation codes 01, 10 and 11.
- R10: When `start` is low, `result`, `carry` and `wr_en` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation |
| op | input | 2 | 00 test, 01 complement, 10 reset, 11 set |
| is_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| idx_from_reg | input | 1 | 1 = index from `reg_idx`, 0 = from `imm_idx` |
| imm_idx | input | 8 | Immediate bit index |
| reg_idx | input | 32 | Register bit index |
| dst_in | input | 32 | Destination operand |
| result | output | 32 | Updated destination |
| wr_en | output | 1 | Destination should be written |
| carry | output | 1 | Tested bit before change |
| done | output | 1 | Result valid pulse |

## Verification
Random operands, indices, codes and width selects are checked against a bench model. Directed cases target the index boundaries:
- Indices 15, 16, 31 and 32, and immediates above the width, which check the modulo reduction separately for each width.
- Register indices with high garbage bits, which show that only the low bits are used.
- Destination values of all zeros and all ones, which tell set and reset apart from complement.
- Idle cycles with changing inputs, which check that the registered outputs hold.

// File: rtl/btm_pkg.sv
// Package: shared types for the bit test and modify unit.
// Assumes: operation encoding is fixed by the instruction decoder.
package btm_pkg;
    typedef enum logic [1:0] {
        BOP_TEST = 2'b00,
        BOP_COMP = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_SET  = 2'b11
    } bop_e;
endpackage

// File: rtl/btm_index.sv
// Module: btm_index
// Picks the bit index source and reduces it modulo the operand width.
// Assumes: wide width is a power of two and twice the narrow width.
module btm_index #(
    parameter int WIDE   = 32,
    parameter int NARROW = 16,
    parameter int IMM_W  = 8,
    localparam int KW    = $clog2(WIDE),
    localparam int NKW   = $clog2(NARROW)
) (
    input  logic             idx_from_reg,
    input  logic             is_wide,
    input  logic [IMM_W-1:0] imm_idx,
    input  logic [WIDE-1:0]  reg_idx,
    output logic [KW-1:0]    bit_k
);
    logic [KW-1:0] raw_k;

    // Select the index source and keep only its low bits.
    always_comb begin
        raw_k = idx_from_reg ? reg_idx[KW-1:0] : imm_idx[KW-1:0];
        bit_k = is_wide ? raw_k : {{(KW-NKW){1'b0}}, raw_k[NKW-1:0]};
    end
endmodule

// File: rtl/btm_modify.sv
// Module: btm_modify
// Reads the addressed bit and builds the modified operand.
// Assumes: index already reduced to the operand width.
module btm_modify
    import btm_pkg::*;
#(
    parameter int WIDE   = 32,
    parameter int NARROW = 16,
    localparam int KW    = $clog2(WIDE)
) (
    input  logic [WIDE-1:0] dst,
    input  logic            is_wide,
    input  logic [KW-1:0]   bit_k,
    input  logic [1:0]      op,
    output logic [WIDE-1:0] new_val,
    output logic            tested,
    output logic            writes
);
    logic [WIDE-1:0] masked;
    logic [WIDE-1:0] onehot;

    // Mask the operand to its width and form the one-hot select.
    always_comb begin
        masked = is_wide ? dst : {{(WIDE-NARROW){1'b0}}, dst[NARROW-1:0]};
        onehot = {{(WIDE-1){1'b0}}, 1'b1} << bit_k;
    end

    // Apply the operation to the selected bit only.
    always_comb begin
        tested = masked[bit_k];
        writes = (op != BOP_TEST);
        unique case (bop_e'(op))
            BOP_TEST: new_val = masked;
            BOP_COMP: new_val = masked ^ onehot;
            BOP_CLR:  new_val = masked & ~onehot;
            default:  new_val = masked | onehot;
        endcase
    end

    // Immediate checks: only the selected bit may differ.
    always_comb begin
        assert ((new_val & ~onehot) == (masked & ~onehot)) else $error("assert_other_bits_R8");
        if (op == BOP_SET) assert (new_val[bit_k]) else $error("assert_set_bit_R8");
    end
endmodule

// File: rtl/bit_test_modify.sv
// Module: bit_test_modify (top)
// Bit test with optional complement/reset/set of the tested bit; one-cycle registered result.
// Assumes: one operation per start pulse; outputs hold between starts.
module bit_test_modify #(
    parameter int WIDE   = 32,
    parameter int NARROW = 16,
    parameter int IMM_W  = 8,
    localparam int KW    = $clog2(WIDE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic             is_wide,
    input  logic             idx_from_reg,
    input  logic [IMM_W-1:0] imm_idx,
    input  logic [WIDE-1:0]  reg_idx,
    input  logic [WIDE-1:0]  dst_in,
    output logic [WIDE-1:0]  result,
    output logic             wr_en,
    output logic             carry,
    output logic             done
);
    logic [KW-1:0]   bit_k;
    logic [WIDE-1:0] new_val;
    logic            tested;
    logic            writes;

    btm_index #(.WIDE(WIDE), .NARROW(NARROW), .IMM_W(IMM_W)) u_index (
        .idx_from_reg(idx_from_reg),
        .is_wide     (is_wide),
        .imm_idx     (imm_idx),
        .reg_idx     (reg_idx),
        .bit_k       (bit_k)
    );

    btm_modify #(.WIDE(WIDE), .NARROW(NARROW)) u_modify (
        .dst    (dst_in),
        .is_wide(is_wide),
        .bit_k  (bit_k),
        .op     (op),
        .new_val(new_val),
        .tested (tested),
        .writes (writes)
    );

    // Register results on start; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            wr_en  <= 1'b0;
            carry  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                result <= new_val;
                wr_en  <= writes;
                carry  <= tested;
            end
        end
    end

    assert_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_done_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(carry) && $stable(wr_en)));
    assert_test_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'b00) |=> !wr_en);
    assert_modify_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op != 2'b00) |=> wr_en);
    assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !is_wide) |=> (result[WIDE-1:NARROW] == '0));
endmodule

// File: tb/bit_test_modify_tb.sv
module bit_test_modify_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  op;
    logic        is_wide;
    logic        idx_from_reg;
    logic [7:0]  imm_idx;
    logic [31:0] reg_idx;
    logic [31:0] dst_in;
    logic [31:0] result;
    logic        wr_en;
    logic        carry;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    bit_test_modify u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_wide(is_wide),
        .idx_from_reg(idx_from_reg), .imm_idx(imm_idx), .reg_idx(reg_idx),
        .dst_in(dst_in), .result(result), .wr_en(wr_en), .carry(carry), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    function automatic int unsigned eff_idx(logic w, logic fr, logic [7:0] im, logic [31:0] rg);
        int unsigned raw = fr ? rg : {24'd0, im};
        return w ? (raw % 32) : (raw % 16);
    endfunction

    function automatic logic [31:0] exp_res(logic [1:0] o, logic w, int unsigned k, logic [31:0] d);
        logic [31:0] m = w ? d : {16'd0, d[15:0]};
        case (o)
            2'b00: ;
            2'b01: m[k] = ~m[k];
            2'b10: m[k] = 1'b0;
            default: m[k] = 1'b1;
        endcase
        return m;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [1:0] o, logic w, logic fr, logic [7:0] im, logic [31:0] rg, logic [31:0] d);
        int unsigned k = eff_idx(w, fr, im, rg);
        logic [31:0] m = w ? d : {16'd0, d[15:0]};
        @(negedge clk);
        start = 1; op = o; is_wide = w; idx_from_reg = fr; imm_idx = im; reg_idx = rg; dst_in = d;
        @(negedge clk);
        start = 0;
        chk("R2 done", {31'd0, done}, 32'd1);
        chk("R3 carry", {31'd0, carry}, {31'd0, m[k]});
        chk("R6/R7/R8 result (R4/R5 index)", result, exp_res(o, w, k, d));
        chk("R9/R6 wr_en", {31'd0, wr_en}, {31'd0, o != 2'b00});
        // Idle cycle with scrambled inputs: R10 hold
        dst_in = ~d; op = ~o; imm_idx = im + 8'd3;
        @(negedge clk);
        chk("R2 done low", {31'd0, done}, 32'd0);
        chk("R10 hold", result, exp_res(o, w, k, d));
        chk("R10 carry hold", {31'd0, carry}, {31'd0, m[k]});
    endtask

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 0; start = 0; op = 0; is_wide = 0; idx_from_reg = 0;
        imm_idx = 0; reg_idx = 0; dst_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R1 result", result, 32'd0);
        chk("R1 flags", {29'd0, done, carry, wr_en}, 32'd0);
        rst_n = 1;
        // Directed corners
        run_op(2'b00, 1'b1, 1'b0, 8'd31, 32'd0, 32'h8000_0000);   // R3 top bit
        run_op(2'b01, 1'b1, 1'b0, 8'd32, 32'd0, 32'h0000_0000);   // R4 32 -> 0
        run_op(2'b11, 1'b0, 1'b0, 8'd16, 32'd0, 32'hABCD_0000);   // R4 16 -> 0, upper ignored
        run_op(2'b10, 1'b0, 1'b0, 8'd15, 32'd0, 32'hFFFF_FFFF);   // R8 clear
        run_op(2'b11, 1'b1, 1'b1, 8'd0, 32'hFFFF_FFE7, 32'd0);    // R5 reg idx 7
        run_op(2'b10, 1'b1, 1'b1, 8'd0, 32'h1234_567F, 32'hFFFF_FFFF); // R5 31
        run_op(2'b01, 1'b0, 1'b1, 8'd0, 32'h0000_0019, 32'hFFFF_FFFF); // R7 idx 9
        run_op(2'b00, 1'b0, 1'b0, 8'd255, 32'd0, 32'h1234_8000);  // R6 test
        // Random
        for (int i = 0; i < 300; i++)
            run_op(2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), $urandom, $urandom);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule